// File: doc/BRIEF.md
# Indexed Battery-Style Register File with Hardware Checksum

This block holds a small byte-wide configuration store that a host reaches through two ports on one simple byte bus. One port is an index (pointer) register; the other is a data window that reads or writes the byte the pointer selects. Software first loads the pointer, then moves data through the window. The block models the nonvolatile configuration area of a PC-class system controller. It keeps no time, raises no alarms and keeps nothing across power loss.

After every reset the block rebuilds its contents without help from the host. A sequencer first copies an initial image, given as a parameter, into the storage array, one byte per clock. It then walks a fixed span of configuration bytes and adds them into a 16-bit sum. It writes that sum into two fixed checksum locations, most significant byte first. Until that sequence ends, the `ready` output stays low and host requests are dropped. After it ends, the checksum is never recomputed. Later host writes change the array directly, checksum bytes included.

The pointer is seven bits wide, and reads of the index port return all seven bits. The data window decodes only the low six bits, so pointer values 64 to 127 fall back onto locations 0 to 63.

Top module: `cmos_regfile`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, `ready` is 0, `rd_data` is 0 and the stored pointer is 0.
- R2: After reset falls, `ready` rises within DEPTH + (number of summed bytes) + 4 cycles and then stays high until the next reset.
- R3: A request (`req`=1) made while `ready` is 0 is ignored. It changes neither the pointer nor any stored byte, and `rd_data` stays 0.
- R4: A write to the index port (`port_sel`=0) stores `wdata[6:0]`. A read of the index port returns the stored pointer in `rd_data[6:0]`, with `rd_data[7]`=0.
- R5: A data port access (`port_sel`=1) addresses location pointer[5:0]. Pointer values 64+n and n reach the same byte.
- R6: With the default image, bytes 0x00 to 0x09 reset to 0x00. Bytes 0x0A, 0x0B, 0x0C and 0x0D reset to 0x26, 0x02, 0x50 and 0x80. Every other byte a resets to (7*a + 0x11) mod 256, except the two checksum bytes.
- R7: Once `ready` is high, byte 0x2E holds bits 15:8 and byte 0x2F holds bits 7:0 of the 16-bit sum of the bytes at 0x10 through 0x2C inclusive. The high byte is written the cycle before the low byte.
- R8: A data write after initialisation updates the addressed byte, checksum bytes included. It does not cause the checksum to be recomputed.
- R9: A reset at any time, including during initialisation, restores the image, clears the pointer and repeats the checksum pass.
- R10: An accepted read drives `rd_data` from the clock edge that accepts it. The value holds until the next accepted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe; accepted in a cycle where ready is high |
| wr | input | 1 | 1 = write, 0 = read |
| port_sel | input | 1 | 0 = index port, 1 = data port |
| wdata | input | 8 | Write data |
| ready | output | 1 | High once the initial load and checksum have finished |
| rd_data | output | 8 | Read data of the last accepted read |

## Verification
The bench builds the block with its default parameters: a 64-byte array, a 7-bit pointer and the default image. With this configuration a full sweep is cheap. The bench reads every location after reset, writes and reads back all 128 pointer codes, and checks aliasing by writing through every upper pointer code and reading through its lower twin. It also issues resets in the middle of the load and checksum passes and issues requests while `ready` is low. Against all of these, it compares the array and both checksum bytes with values it computes from the image rule.

// File: rtl/cmos_pkg.sv
package cmos_pkg;

  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 256;

  typedef enum logic [2:0] {
    PH_LOAD,
    PH_SUM,
    PH_DRAIN,
    PH_WHI,
    PH_WLO,
    PH_DONE
  } init_phase_t;

  localparam logic PORT_INDEX = 1'b0;
  localparam logic PORT_DATA  = 1'b1;

  // Default power-on image: zeroed clock bytes, four status bytes,
  // and a simple arithmetic fill everywhere else.
  function automatic logic [MAX_BYTES*BYTE_W-1:0] default_image();
    logic [MAX_BYTES*BYTE_W-1:0] img;
    img = '0;
    for (int a = 0; a < MAX_BYTES; a++) begin
      logic [BYTE_W-1:0] b;
      if (a <= 9)       b = 8'h00;
      else if (a == 10) b = 8'h26;
      else if (a == 11) b = 8'h02;
      else if (a == 12) b = 8'h50;
      else if (a == 13) b = 8'h80;
      else              b = 8'((7 * a + 17) % 256);
      img[a*BYTE_W +: BYTE_W] = b;
    end
    return img;
  endfunction

endpackage

// File: rtl/cmos_ram.sv
module cmos_ram #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] q
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/cmos_init_seq.sv
module cmos_init_seq
  import cmos_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int SUM_LO     = 'h10,
  parameter int SUM_HI     = 'h2C,
  parameter int CK_HI_ADDR = 'h2E,
  parameter int CK_LO_ADDR = 'h2F,
  parameter logic [MAX_BYTES*BYTE_W-1:0] INIT_IMAGE = default_image()
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BYTE_W-1:0] ram_q,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [BYTE_W-1:0] wdata,
  output logic              re,
  output logic [ADDR_W-1:0] raddr,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] LAST_LOAD = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W-1:0] FIRST_SUM = ADDR_W'(SUM_LO);
  localparam logic [ADDR_W-1:0] LAST_SUM  = ADDR_W'(SUM_HI);
  localparam logic [ADDR_W-1:0] CK_HI     = ADDR_W'(CK_HI_ADDR);
  localparam logic [ADDR_W-1:0] CK_LO     = ADDR_W'(CK_LO_ADDR);

  init_phase_t       phase;
  logic [ADDR_W-1:0] load_cnt;
  logic [ADDR_W-1:0] sum_ptr;
  logic              pend;
  logic [15:0]       acc;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_LOAD;
      load_cnt <= '0;
      sum_ptr  <= FIRST_SUM;
      pend     <= 1'b0;
      acc      <= '0;
      done     <= 1'b0;
    end else begin
      case (phase)
        PH_LOAD: begin
          load_cnt <= load_cnt + 1'b1;
          if (load_cnt == LAST_LOAD) phase <= PH_SUM;
        end
        PH_SUM: begin
          pend    <= 1'b1;
          sum_ptr <= sum_ptr + 1'b1;
          if (pend) acc <= acc + {8'h00, ram_q};
          if (sum_ptr == LAST_SUM) phase <= PH_DRAIN;
        end
        PH_DRAIN: begin
          pend  <= 1'b0;
          acc   <= acc + {8'h00, ram_q};
          phase <= PH_WHI;
        end
        PH_WHI: phase <= PH_WLO;
        PH_WLO: begin
          phase <= PH_DONE;
          done  <= 1'b1;
        end
        default: phase <= PH_DONE;
      endcase
    end
  end

  always_comb begin
    we    = 1'b0;
    waddr = load_cnt;
    wdata = INIT_IMAGE[load_cnt*BYTE_W +: BYTE_W];
    case (phase)
      PH_LOAD: we = 1'b1;
      PH_WHI: begin
        we    = 1'b1;
        waddr = CK_HI;
        wdata = acc[15:8];
      end
      PH_WLO: begin
        we    = 1'b1;
        waddr = CK_LO;
        wdata = acc[7:0];
      end
      default: we = 1'b0;
    endcase
  end

  assign re    = (phase == PH_SUM);
  assign raddr = sum_ptr;
endmodule

// File: rtl/cmos_host_if.sv
module cmos_host_if
  import cmos_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ready,
  input  logic              req,
  input  logic              wr,
  input  logic              port_sel,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [BYTE_W-1:0] ram_q,
  output logic              ram_we,
  output logic              ram_re,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [BYTE_W-1:0] ram_wdata,
  output logic [BYTE_W-1:0] rd_data
);
  localparam int PAD_W = BYTE_W - IDX_W;

  logic             accept;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] idx_rd_q;
  logic             data_sel_q;

  assign accept = req && ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx        <= '0;
      idx_rd_q   <= '0;
      data_sel_q <= 1'b0;
    end else if (accept) begin
      if (wr) begin
        if (port_sel == PORT_INDEX) idx <= wdata[IDX_W-1:0];
      end else begin
        data_sel_q <= (port_sel == PORT_DATA);
        if (port_sel == PORT_INDEX) idx_rd_q <= idx;
      end
    end
  end

  assign ram_we    = accept && wr && (port_sel == PORT_DATA);
  assign ram_re    = accept && !wr && (port_sel == PORT_DATA);
  assign ram_addr  = idx[ADDR_W-1:0];
  assign ram_wdata = wdata;

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = data_sel_q ? ram_q : {{PAD_W{1'b0}}, idx_rd_q};
    end else begin : g_nopad
      assign rd_data = data_sel_q ? ram_q : BYTE_W'(idx_rd_q);
    end
  endgenerate
endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
  import cmos_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int IDX_W      = 7,
  parameter int SUM_LO     = 'h10,
  parameter int SUM_HI     = 'h2C,
  parameter int CK_HI_ADDR = 'h2E,
  parameter int CK_LO_ADDR = 'h2F,
  parameter logic [MAX_BYTES*BYTE_W-1:0] INIT_IMAGE = default_image()
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic        wr,
  input  logic        port_sel,
  input  logic [7:0]  wdata,
  output logic        ready,
  output logic [7:0]  rd_data
);
  logic              seq_we, seq_re, seq_done;
  logic [ADDR_W-1:0] seq_waddr, seq_raddr;
  logic [BYTE_W-1:0] seq_wdata;

  logic              host_we, host_re;
  logic [ADDR_W-1:0] host_addr;
  logic [BYTE_W-1:0] host_wdata;

  logic              ram_we, ram_re;
  logic [ADDR_W-1:0] ram_waddr, ram_raddr;
  logic [BYTE_W-1:0] ram_wdata, ram_q;

  cmos_init_seq #(
    .ADDR_W(ADDR_W), .SUM_LO(SUM_LO), .SUM_HI(SUM_HI),
    .CK_HI_ADDR(CK_HI_ADDR), .CK_LO_ADDR(CK_LO_ADDR),
    .INIT_IMAGE(INIT_IMAGE)
  ) u_seq (
    .clk(clk), .rst(rst), .ram_q(ram_q),
    .we(seq_we), .waddr(seq_waddr), .wdata(seq_wdata),
    .re(seq_re), .raddr(seq_raddr), .done(seq_done)
  );

  cmos_host_if #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_host (
    .clk(clk), .rst(rst), .ready(seq_done),
    .req(req), .wr(wr), .port_sel(port_sel), .wdata(wdata),
    .ram_q(ram_q), .ram_we(host_we), .ram_re(host_re),
    .ram_addr(host_addr), .ram_wdata(host_wdata), .rd_data(rd_data)
  );

  always_comb begin
    if (seq_done) begin
      ram_we    = host_we;
      ram_waddr = host_addr;
      ram_wdata = host_wdata;
      ram_re    = host_re;
      ram_raddr = host_addr;
    end else begin
      ram_we    = seq_we;
      ram_waddr = seq_waddr;
      ram_wdata = seq_wdata;
      ram_re    = seq_re;
      ram_raddr = seq_raddr;
    end
  end

  cmos_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .re(ram_re), .raddr(ram_raddr), .q(ram_q)
  );

  assign ready = seq_done;
endmodule

// File: rtl/cmos_regfile_chk.sv
module cmos_regfile_chk #(
  parameter int ADDR_W     = 6,
  parameter int IDX_W      = 7,
  parameter int SUM_LO     = 'h10,
  parameter int SUM_HI     = 'h2C,
  parameter int CK_HI_ADDR = 'h2E,
  parameter int CK_LO_ADDR = 'h2F
) (
  input logic              clk,
  input logic              rst,
  input logic              req,
  input logic              wr,
  input logic              port_sel,
  input logic [7:0]        rd_data,
  input logic              ready,
  input logic              seq_we,
  input logic [ADDR_W-1:0] seq_waddr
);
  localparam int LIMIT = (1 << ADDR_W) + (SUM_HI - SUM_LO + 1) + 4;
  localparam logic [ADDR_W-1:0] CK_HI = ADDR_W'(CK_HI_ADDR);
  localparam logic [ADDR_W-1:0] CK_LO = ADDR_W'(CK_LO_ADDR);

  int unsigned wait_cnt;
  always_ff @(posedge clk) begin
    if (rst || ready) wait_cnt <= 0;
    else              wait_cnt <= wait_cnt + 1;
  end

  // R1 / R9: first cycle after reset is never ready
  p_ready_low_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !ready);

  // R2: ready is sticky until reset
  p_ready_sticky_r2: assert property (@(posedge clk) disable iff (rst)
    ready |=> ready);

  // R2: initialisation finishes within the bound
  p_init_bound_r2: assert property (@(posedge clk) disable iff (rst)
    wait_cnt <= LIMIT);

  // R3: nothing reaches the read port before ready
  p_idle_rdata_r3: assert property (@(posedge clk) disable iff (rst)
    !ready |-> rd_data == 8'h00);

  // R4: index reads never carry bits above the pointer width
  p_idx_read_width_r4: assert property (@(posedge clk) disable iff (rst)
    (req && ready && !wr && !port_sel) |=> ((rd_data >> IDX_W) == 8'h00));

  // R7: high checksum byte is followed by the low checksum byte
  p_ck_order_r7: assert property (@(posedge clk) disable iff (rst)
    (seq_we && seq_waddr == CK_HI) |=> (seq_we && seq_waddr == CK_LO));

  // R7: ready rises only right after the low checksum byte is stored
  p_ready_after_ck_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(seq_we && seq_waddr == CK_LO));
endmodule

bind cmos_regfile cmos_regfile_chk #(
  .ADDR_W(ADDR_W), .IDX_W(IDX_W), .SUM_LO(SUM_LO), .SUM_HI(SUM_HI),
  .CK_HI_ADDR(CK_HI_ADDR), .CK_LO_ADDR(CK_LO_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .req(req), .wr(wr), .port_sel(port_sel),
  .rd_data(rd_data), .ready(ready), .seq_we(seq_we), .seq_waddr(seq_waddr)
);

// File: tb/cmos_regfile_test.sv
module cmos_regfile_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req = 1'b0;
  logic       wr = 1'b0;
  logic       port_sel = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic       ready;
  logic [7:0] rd_data;

  int vectors = 0;
  int errors  = 0;
  localparam int INIT_LIMIT = 64 + 29 + 4;

  cmos_regfile uut (
    .clk(clk), .rst(rst), .req(req), .wr(wr), .port_sel(port_sel),
    .wdata(wdata), .ready(ready), .rd_data(rd_data)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] img(int a);
    if (a <= 9)  return 8'h00;
    if (a == 10) return 8'h26;
    if (a == 11) return 8'h02;
    if (a == 12) return 8'h50;
    if (a == 13) return 8'h80;
    return 8'((7 * a + 17) % 256);
  endfunction

  function automatic logic [15:0] csum();
    logic [15:0] s = 16'h0000;
    for (int a = 16; a <= 44; a++) s = s + {8'h00, img(a)};
    return s;
  endfunction

  function automatic logic [7:0] expect_byte(int a);
    logic [15:0] s = csum();
    if (a == 46) return s[15:8];
    if (a == 47) return s[7:0];
    return img(a);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic w, input logic p, input logic [7:0] d,
                        output logic [7:0] r);
    @(negedge clk);
    req = 1'b1; wr = w; port_sel = p; wdata = d;
    @(negedge clk);
    req = 1'b0; wr = 1'b0;
    r = rd_data;
  endtask

  task automatic set_idx(input logic [7:0] v);
    logic [7:0] r;
    access(1'b1, 1'b0, v, r);
  endtask

  task automatic read_at(input logic [7:0] i, output logic [7:0] r);
    set_idx(i);
    access(1'b0, 1'b1, 8'h00, r);
  endtask

  task automatic write_at(input logic [7:0] i, input logic [7:0] d);
    logic [7:0] r;
    set_idx(i);
    access(1'b1, 1'b1, d, r);
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin : main
    logic [7:0] r;
    int n;
    logic [15:0] s;

    s = csum();
    repeat (3) @(negedge clk);
    // R1: state during reset
    check(ready == 1'b0, "R1 ready in reset", ready, 0);
    check(rd_data == 8'h00, "R1 rd_data in reset", rd_data, 0);
    rst = 1'b0;
    @(negedge clk);
    check(ready == 1'b0, "R1 ready after reset", ready, 0);

    // R3: requests while not ready are dropped
    access(1'b1, 1'b0, 8'h23, r);
    check(r == 8'h00, "R3 rd_data while busy", r, 0);
    access(1'b1, 1'b1, 8'hEE, r);
    access(1'b0, 1'b1, 8'h00, r);
    check(r == 8'h00, "R3 data read while busy", r, 0);

    wait_ready(n);
    check(ready && n + 3 <= INIT_LIMIT, "R2 ready within bound", n + 3, INIT_LIMIT);

    // R1 / R3: pointer still zero after ignored index write
    access(1'b0, 1'b0, 8'h00, r);
    check(r == 8'h00, "R1 R3 pointer after init", r, 0);
    // R3: byte 0 not overwritten by ignored data write
    read_at(8'h00, r);
    check(r == img(0), "R3 byte 0 untouched", r, img(0));

    // R6 R7: full sweep of reset contents
    for (int a = 0; a < 64; a++) begin
      read_at(8'(a), r);
      check(r == expect_byte(a), $sformatf("R6 R7 image byte %0h", a), r, expect_byte(a));
    end
    read_at(8'h0A, r); check(r == 8'h26, "R6 status A", r, 8'h26);
    read_at(8'h0D, r); check(r == 8'h80, "R6 status D", r, 8'h80);
    read_at(8'h2E, r); check(r == s[15:8], "R7 checksum high", r, s[15:8]);
    read_at(8'h2F, r); check(r == s[7:0], "R7 checksum low", r, s[7:0]);

    // R4: every index code
    for (int v = 0; v < 256; v++) begin
      set_idx(8'(v));
      access(1'b0, 1'b0, 8'h00, r);
      check(r == (8'(v) & 8'h7F), $sformatf("R4 index %0h", v), r, v & 8'h7F);
    end

    // R10: read value holds across writes and idle cycles
    read_at(8'h11, r);
    set_idx(8'h05);
    access(1'b1, 1'b1, 8'h99, r);
    repeat (3) @(negedge clk);
    check(rd_data == img(17), "R10 read data held", rd_data, img(17));

    // R5: aliasing through upper pointer codes
    for (int a = 0; a < 64; a++) write_at(8'(a + 64), 8'(a ^ 8'hA5));
    for (int a = 0; a < 64; a++) begin
      read_at(8'(a), r);
      check(r == 8'(a ^ 8'hA5), $sformatf("R5 alias %0h", a), r, a ^ 8'hA5);
    end

    // R9: reset after modification restores everything
    do_reset();
    wait_ready(n);
    check(ready && n + 1 <= INIT_LIMIT, "R9 ready again", n + 1, INIT_LIMIT);
    access(1'b0, 1'b0, 8'h00, r);
    check(r == 8'h00, "R9 pointer cleared", r, 0);
    for (int a = 0; a < 64; a++) begin
      read_at(8'(a), r);
      check(r == expect_byte(a), $sformatf("R9 restored byte %0h", a), r, expect_byte(a));
    end

    // R8: writes after init, no recompute
    write_at(8'h15, 8'h00);
    read_at(8'h15, r); check(r == 8'h00, "R8 byte updated", r, 0);
    read_at(8'h2E, r); check(r == s[15:8], "R8 checksum high kept", r, s[15:8]);
    read_at(8'h2F, r); check(r == s[7:0], "R8 checksum low kept", r, s[7:0]);
    write_at(8'h2F, 8'h5A);
    read_at(8'h2F, r); check(r == 8'h5A, "R8 checksum byte writable", r, 8'h5A);
    repeat (200) @(negedge clk);
    read_at(8'h2F, r); check(r == 8'h5A, "R8 no later recompute", r, 8'h5A);

    // R9: reset in the middle of the load and of the sum pass
    do_reset();
    repeat (20) @(negedge clk);
    do_reset();
    repeat (75) @(negedge clk);
    check(ready == 1'b0, "R9 busy mid sum", ready, 0);
    do_reset();
    access(1'b1, 1'b0, 8'h2E, r);
    wait_ready(n);
    check(ready == 1'b1, "R9 ready after restarts", ready, 1);
    access(1'b0, 1'b0, 8'h00, r);
    check(r == 8'h00, "R9 R3 pointer after restarts", r, 0);
    read_at(8'h15, r); check(r == img(21), "R9 byte reverted", r, img(21));
    read_at(8'h2E, r); check(r == s[15:8], "R9 checksum high", r, s[15:8]);
    read_at(8'h2F, r); check(r == s[7:0], "R9 checksum low", r, s[7:0]);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule